// File: doc/BRIEF.md
# Circular and Bit-Reversed Pointer Address Generator

This block produces data-memory addresses from banks of pointer registers. Every generator unit has its own pointer bank, its own step bank and its own per-pointer buffer lengths. An access request names one pointer and one step. The unit presents the pointer's present value as the address and then advances the pointer by the step. When the pointer's length is not zero, the advance wraps inside a circular buffer. The buffer starts at the value that was last loaded into the pointer.

A request can also be step-only. A step-only request advances the pointer and produces no address. A mode pin on each unit mirrors the bit order of the emitted address, which gives the scrambled ordering that FFTs need. Two units run side by side, so two pointers can advance in the same cycle.

Each unit takes requests over a valid/ready interface and returns addresses over a valid/ready interface. A one-entry output register sits between the two. A request is taken only when that register is empty or is being drained in the same cycle (`req_ready = !addr_valid || addr_ready`). This rule applies to step-only requests as well. While `addr_ready` is low, a pending address is held unchanged.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset, every pointer, step, length and base register of both units is 0, `addr_valid` is low and `req_ready` is high.
- R2: The address for a taken memory request (`req_nomem`=0) is the pointer value before the update. It appears with `addr_valid` high on the cycle after acceptance.
- R3: With length 0, a taken request sets the pointer to (pointer + step) modulo 2^14. Steps are 14-bit two's complement.
- R4: With a nonzero length L and a positive step smaller than L, the pointer becomes base + ((pointer − base + step) mod L). The base is the last value written to that pointer.
- R5: The same wrap applies to a negative step whose magnitude is smaller than L. A result below the base is moved up by L.
- R6: A step-only request (`req_nomem`=1) updates the pointer and produces no address (`addr_valid` stays low).
- R7: While `bitrev_en` of a unit is high, the emitted address is the pointer with bit i moved to bit 13−i. The stored pointer is not mirrored.
- R8: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high, `addr_data` is stable and `req_ready` is low.
- R9: The two units accept requests in the same cycle. Each updates only its own pointers.
- R10: Register writes use `wr_kind` 0 = pointer (also sets the base), 1 = step, 2 = length, and 3 = none. If a pointer write and a request's update hit the same pointer in one cycle, the written value is kept and the request's address is the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_gen | input | 1 | Unit chosen by the write |
| wr_kind | input | 2 | Register kind: 0 pointer, 1 step, 2 length, 3 none |
| wr_sel | input | 2 | Register number within the kind |
| wr_data | input | 14 | Write value |
| bitrev_en | input | 2 | Per-unit mirrored-address mode |
| req_valid | input | 2 | Per-unit request valid |
| req_ready | output | 2 | Per-unit request ready |
| req_isel | input | 4 | Pointer select, 2 bits per unit (unit 0 in bits 1:0) |
| req_msel | input | 4 | Step select, 2 bits per unit |
| req_nomem | input | 2 | Per-unit step-only flag |
| addr_valid | output | 2 | Per-unit address valid |
| addr_ready | input | 2 | Per-unit address ready |
| addr_data | output | 28 | Addresses, 14 bits per unit (unit 0 in bits 13:0) |

## Verification
Two pairs of functions can fall in the same cycle. The first is a register load and a post-update of the same pointer in one unit. The bench provokes it by raising a pointer write and a request on that pointer at the same edge. It judges the result by the address that comes out, which must be the old value, and by the address of the next access, which must be the written value. The second is a request to each unit on the same edge. Both addresses are compared against per-unit scoreboard queues, and the later accesses must show that each unit updated only its own pointer.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [1:0] {
    KIND_PTR  = 2'd0,
    KIND_STEP = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/pag_wrap.sv
module pag_wrap #(
  parameter int W = 14
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] base,
  input  logic [W-1:0] len,
  input  logic [W-1:0] step,
  output logic [W-1:0] nxt
);
  logic signed [W+1:0] off, lens, adj;

  always_comb begin
    off  = $signed({2'b00, cur}) - $signed({2'b00, base}) + $signed({{2{step[W-1]}}, step});
    lens = $signed({2'b00, len});
    adj  = off;
    if (off >= lens)   adj = off - lens;
    else if (off < 0)  adj = off + lens;
    if (len == '0) nxt = cur + step;
    else           nxt = base + adj[W-1:0];
  end
endmodule

// File: rtl/pag_bitrev.sv
module pag_bitrev #(
  parameter int W = 14
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_mirror
    assign dout[b] = din[W-1-b];
  end
endmodule

// File: rtl/pag_unit.sv
module pag_unit
  import pag_pkg::*;
#(
  parameter int W    = 14,
  parameter int NP   = 4,
  parameter int NM   = 4,
  parameter int SW   = 2,
  parameter int ISW  = 2,
  parameter int MSW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_kind,
  input  logic [SW-1:0]  wr_sel,
  input  logic [W-1:0]   wr_data,
  input  logic           bitrev_en,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [ISW-1:0] req_isel,
  input  logic [MSW-1:0] req_msel,
  input  logic           req_nomem,
  output logic           addr_valid,
  input  logic           addr_ready,
  output logic [W-1:0]   addr_data
);
  logic [W-1:0] ptr_q  [NP];
  logic [W-1:0] base_q [NP];
  logic [W-1:0] len_q  [NP];
  logic [W-1:0] step_q [NM];

  logic [W-1:0] cur, cur_base, cur_len, cur_step, nxt, mirrored, emit;
  logic         accept;
  reg_kind_e    kind;

  assign kind      = reg_kind_e'(wr_kind);
  assign req_ready = !addr_valid || addr_ready;
  assign accept    = req_valid && req_ready;
  assign cur       = ptr_q[req_isel];
  assign cur_base  = base_q[req_isel];
  assign cur_len   = len_q[req_isel];
  assign cur_step  = step_q[req_msel];

  pag_wrap #(.W(W)) u_wrap (
    .cur(cur), .base(cur_base), .len(cur_len), .step(cur_step), .nxt(nxt)
  );

  pag_bitrev #(.W(W)) u_rev (.din(cur), .dout(mirrored));

  assign emit = bitrev_en ? mirrored : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        ptr_q[i]  <= '0;
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
      for (int j = 0; j < NM; j++) step_q[j] <= '0;
    end else begin
      if (accept) ptr_q[req_isel] <= nxt;
      if (wr_en) begin
        case (kind)
          KIND_PTR: if (32'(wr_sel) < NP) begin
            ptr_q[wr_sel[ISW-1:0]]  <= wr_data;
            base_q[wr_sel[ISW-1:0]] <= wr_data;
          end
          KIND_STEP: if (32'(wr_sel) < NM) step_q[wr_sel[MSW-1:0]] <= wr_data;
          KIND_LEN:  if (32'(wr_sel) < NP) len_q[wr_sel[ISW-1:0]] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_data  <= '0;
    end else if (accept && !req_nomem) begin
      addr_valid <= 1'b1;
      addr_data  <= emit;
    end else if (addr_ready) begin
      addr_valid <= 1'b0;
    end
  end

  logic [W-1:0] step_mag;
  logic         in_buf, step_small, nxt_in_buf;
  assign step_mag   = cur_step[W-1] ? (~cur_step + 1'b1) : cur_step;
  assign step_small = step_mag < cur_len;
  assign in_buf     = ({1'b0, cur} >= {1'b0, cur_base}) &&
                      ({1'b0, cur} < ({1'b0, cur_base} + {1'b0, cur_len}));
  assign nxt_in_buf = ({1'b0, nxt} >= {1'b0, cur_base}) &&
                      ({1'b0, nxt} < ({1'b0, cur_base} + {1'b0, cur_len}));

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_data)); // R8
  AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_nomem |=> addr_valid); // R2
  AST_STEP_ONLY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_nomem && !addr_valid |=> !addr_valid); // R6
  AST_WRAP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cur_len != '0) && in_buf && step_small |-> nxt_in_buf); // R4
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int ADDR_W  = 14,
  parameter int NUM_PTR = 4,
  parameter int NUM_STP = 4,
  parameter int NUM_GEN = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_GEN)-1:0]    wr_gen,
  input  logic [1:0]                    wr_kind,
  input  logic [((NUM_PTR > NUM_STP) ? $clog2(NUM_PTR) : $clog2(NUM_STP))-1:0] wr_sel,
  input  logic [ADDR_W-1:0]             wr_data,
  input  logic [NUM_GEN-1:0]            bitrev_en,
  input  logic [NUM_GEN-1:0]            req_valid,
  output logic [NUM_GEN-1:0]            req_ready,
  input  logic [NUM_GEN*$clog2(NUM_PTR)-1:0] req_isel,
  input  logic [NUM_GEN*$clog2(NUM_STP)-1:0] req_msel,
  input  logic [NUM_GEN-1:0]            req_nomem,
  output logic [NUM_GEN-1:0]            addr_valid,
  input  logic [NUM_GEN-1:0]            addr_ready,
  output logic [NUM_GEN*ADDR_W-1:0]     addr_data
);
  localparam int ISW = $clog2(NUM_PTR);
  localparam int MSW = $clog2(NUM_STP);
  localparam int SW  = (ISW > MSW) ? ISW : MSW;
  localparam int GSW = $clog2(NUM_GEN);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_unit
    logic sel_wr;
    assign sel_wr = wr_en && (wr_gen == GSW'(g));
    pag_unit #(.W(ADDR_W), .NP(NUM_PTR), .NM(NUM_STP), .SW(SW), .ISW(ISW), .MSW(MSW)) u_unit (
      .clk(clk), .rst_n(rst_n),
      .wr_en(sel_wr), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
      .bitrev_en(bitrev_en[g]),
      .req_valid(req_valid[g]), .req_ready(req_ready[g]),
      .req_isel(req_isel[g*ISW +: ISW]), .req_msel(req_msel[g*MSW +: MSW]),
      .req_nomem(req_nomem[g]),
      .addr_valid(addr_valid[g]), .addr_ready(addr_ready[g]),
      .addr_data(addr_data[g*ADDR_W +: ADDR_W])
    );
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> addr_valid == '0); // R1
endmodule

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        wr_gen = 0;
  logic [1:0]  wr_kind = 0;
  logic [1:0]  wr_sel = 0;
  logic [13:0] wr_data = 0;
  logic [1:0]  bitrev_en = 0, req_valid = 0, req_nomem = 0, addr_ready = 2'b11;
  logic [1:0]  req_ready, addr_valid;
  logic [3:0]  req_isel = 0, req_msel = 0;
  logic [27:0] addr_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [13:0] q0[$], q1[$];
  logic [13:0] m_ptr[2][4], m_base[2][4], m_len[2][4], m_step[2][4];

  ptr_addr_gen uut (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] f_next(logic [13:0] p, logic [13:0] b, logic [13:0] l, logic [13:0] s);
    int off;
    off = int'(p) - int'(b) + int'($signed(s));
    if (l == 0) return p + s;
    if (off >= int'(l)) off -= int'(l);
    else if (off < 0) off += int'(l);
    return b + 14'(off);
  endfunction

  function automatic logic [13:0] f_rev(logic [13:0] v);
    logic [13:0] r;
    for (int i = 0; i < 14; i++) r[i] = v[13-i];
    return r;
  endfunction

  task automatic push(int g, logic [13:0] v);
    if (g == 0) q0.push_back(v); else q1.push_back(v);
  endtask

  // monitor: pops the scoreboard as addresses transfer
  always @(negedge clk) if (rst_n) begin
    for (int g = 0; g < 2; g++) begin
      if (addr_valid[g] && addr_ready[g]) begin
        logic [13:0] e;
        if ((g == 0 ? q0.size() : q1.size()) == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6 unit%0d unexpected address actual=%0d expected=none", g, addr_data[g*14 +: 14]);
        end else begin
          e = (g == 0) ? q0.pop_front() : q1.pop_front();
          check($sformatf("R2 scoreboard unit%0d", g), 32'(addr_data[g*14 +: 14]), 32'(e));
        end
      end
    end
  end

  task automatic wreg(int g, int kind, int sel, logic [13:0] d);
    @(negedge clk);
    wr_en = 1; wr_gen = g[0]; wr_kind = kind[1:0]; wr_sel = sel[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (kind)
      0: begin m_ptr[g][sel] = d; m_base[g][sel] = d; end
      1: m_step[g][sel] = d;
      2: m_len[g][sel] = d;
      default: ;
    endcase
  endtask

  task automatic access(int g, int isel, int msel, bit nomem, bit brev);
    @(negedge clk);
    bitrev_en[g] = brev; req_nomem[g] = nomem;
    req_isel[g*2 +: 2] = isel[1:0]; req_msel[g*2 +: 2] = msel[1:0];
    req_valid[g] = 1;
    if (!nomem) push(g, brev ? f_rev(m_ptr[g][isel]) : m_ptr[g][isel]);
    m_ptr[g][isel] = f_next(m_ptr[g][isel], m_base[g][isel], m_len[g][isel], m_step[g][msel]);
    while (!req_ready[g]) @(negedge clk);
    @(negedge clk);
    req_valid[g] = 0;
  endtask

  task automatic access_both(int i0, int m0, int i1, int m1);
    @(negedge clk);
    bitrev_en = 0; req_nomem = 0;
    req_isel = {i1[1:0], i0[1:0]}; req_msel = {m1[1:0], m0[1:0]};
    req_valid = 2'b11;
    push(0, m_ptr[0][i0]); push(1, m_ptr[1][i1]);
    m_ptr[0][i0] = f_next(m_ptr[0][i0], m_base[0][i0], m_len[0][i0], m_step[0][m0]);
    m_ptr[1][i1] = f_next(m_ptr[1][i1], m_base[1][i1], m_len[1][i1], m_step[1][m1]);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] held;
    for (int g = 0; g < 2; g++) for (int i = 0; i < 4; i++) begin
      m_ptr[g][i] = 0; m_base[g][i] = 0; m_len[g][i] = 0; m_step[g][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 addr_valid after reset", 32'(addr_valid), 0);
    check("R1 req_ready after reset", 32'(req_ready), 3);
    access(0, 2, 3, 0, 0);                 // R1: pointer and step read as 0
    access(1, 3, 1, 0, 0);

    // R2 R3 linear stepping
    wreg(0, 0, 0, 14'd100); wreg(0, 1, 0, 14'd3);
    repeat (3) access(0, 0, 0, 0, 0);
    wreg(0, 0, 1, 14'd16380); wreg(0, 1, 1, 14'd5);
    repeat (2) access(0, 1, 1, 0, 0);      // R3 wraps modulo 2^14

    // R4 circular, positive step
    wreg(0, 0, 2, 14'd200); wreg(0, 2, 2, 14'd10); wreg(0, 1, 2, 14'd4);
    repeat (6) access(0, 2, 2, 0, 0);
    // R5 circular, negative step
    wreg(1, 0, 0, 14'd50); wreg(1, 2, 0, 14'd8); wreg(1, 1, 0, 14'h3FFD);
    repeat (5) access(1, 0, 0, 0, 0);

    // R6 step-only
    wreg(0, 0, 3, 14'd20); wreg(0, 1, 3, 14'd7);
    access(0, 3, 3, 1, 0);
    check("R6 no address after step-only", 32'(addr_valid[0]), 0);
    access(0, 3, 3, 1, 0);
    check("R6 no address after second step-only", 32'(addr_valid[0]), 0);
    access(0, 3, 3, 0, 0);                 // expects 34

    // R7 mirrored output, stored pointer untouched
    wreg(1, 0, 1, 14'd1); wreg(1, 1, 1, 14'd2);
    access(1, 1, 1, 0, 1);                 // 0x2000
    access(1, 1, 1, 0, 1);                 // mirror of 3
    access(1, 1, 1, 0, 0);                 // plain 5

    // R8 back-pressure
    @(negedge clk); addr_ready[0] = 0;
    access(0, 0, 0, 0, 0);
    held = addr_data[13:0];
    check("R8 ready low while stalled", 32'(req_ready[0]), 0);
    repeat (2) @(negedge clk);
    check("R8 valid held", 32'(addr_valid[0]), 1);
    check("R8 data stable", 32'(addr_data[13:0]), 32'(held));
    @(posedge clk); #1 addr_ready[0] = 1;
    repeat (2) @(negedge clk);
    check("R8 drained", 32'(addr_valid[0]), 0);

    // R9 both units in one cycle
    access_both(0, 0, 0, 0);
    access_both(0, 0, 0, 0);
    access(0, 0, 0, 0, 0);
    access(1, 0, 0, 0, 0);

    // R10 pointer write collides with post-update on the same pointer
    @(negedge clk);
    wr_en = 1; wr_gen = 0; wr_kind = 2'd0; wr_sel = 2'd0; wr_data = 14'd777;
    req_nomem[0] = 0; bitrev_en[0] = 0; req_isel[1:0] = 0; req_msel[1:0] = 0; req_valid[0] = 1;
    push(0, m_ptr[0][0]);
    m_ptr[0][0] = 14'd777; m_base[0][0] = 14'd777;
    @(negedge clk);
    wr_en = 0; req_valid[0] = 0;
    access(0, 0, 0, 0, 0);                 // R10 expects 777
    wreg(0, 3, 0, 14'd999);                // R10 kind 3 writes nothing
    access(0, 0, 0, 0, 0);                 // expects 780

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained unit0", q0.size(), 0);
    check("R2 scoreboard drained unit1", q1.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule